// File: doc/BRIEF.md
# Slow-Clock Watchdog Timer with Register Access

This block is a watchdog timer for a chip whose timer logic runs at 32.768 kHz. The slow clock is modelled as a one-cycle enable, `tick`, in the bus clock domain. A 32-bit counter counts upward while the watchdog is armed. When the counter wraps past its all-ones value, the block raises a reset request for one timer period and restarts the counter from the load value. An optional prescaler divides the count rate by a power of two.

Software configures the block through a simple register bus: address, write data, write strobe, and combinational read data. Four registers are "posted". A write to one of them is held in a staging slot, and its pending bit stays visible until the write lands in the timer domain a fixed number of ticks later. Arming and disarming each need two magic words, written in order to the arm register. Software services the watchdog by writing the trigger register with a value that differs from its last contents. Such a write copies the load value into the counter.

Register offsets (byte addresses): revision 0x00, control 0x24, counter 0x28, load 0x2C, trigger 0x30, pending status 0x34, arm 0x48. Every other offset reads as zero and ignores writes.

Top module: `wdog32k_top`

## Requirements
- R1: After reset the block is disarmed and reads as follows: counter 0xFFFF0000, load 0xFFFF0000, trigger 0, control 0 (prescaler off), pending status 0. `rst_req` is low.
- R2: Bits 7:0 at offset 0x00 read the parameter `REV_CODE`, and the upper bits read zero. Writes to 0x00 change nothing.
- R3: The arm register (0x48) arms the block when it commits 0x0000BBBB followed by 0x00004444. While armed, with the prescaler off, the counter (0x28) rises by one on each tick.
- R4: Committing 0x0000AAAA followed by 0x00005555 at 0x48 disarms the block, and the counter then holds its value across ticks.
- R5: If the first word of a pair is followed by any word other than its partner, the sequence checker returns to idle. The armed state stays unchanged, so a later lone second word has no effect.
- R6: Committing a trigger value (0x30) that differs from the current trigger contents copies the load register into the counter. Committing the same value leaves the counter unchanged. The trigger register reads back the last committed value.
- R7: An armed counter that steps past 0xFFFFFFFF reloads from the load register. On that tick `rst_req` goes high, and it stays high until the next tick.
- R8: Control bit 5 enables the prescaler and bits 4:2 hold the exponent P. With the prescaler on, the counter advances once every 2^P ticks, counted from arming. Bits 5:2 of the control register read back.
- R9: Pending status (0x34) bit 0 covers control, bit 2 covers load, bit 3 covers trigger and bit 4 covers arm. Each bit sets on the bus write and clears on the second following tick, which is also when the write takes effect.
- R10: A write to a register whose pending bit is set is dropped.
- R11: Control and load writes that commit while the block is armed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable marking each timer clock period |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | Reset request, high for one timer period after overflow |

## Verification
The counting function is exercised in three ways: disarmed, armed with the prescaler off, and armed with divide-by-four. Together these separate "no counting" from "every tick" from "every fourth tick". The overflow run starts eight steps below the wrap point. This pins down the exact tick on which the reload and `rst_req` occur and shows that the request drops on the following tick.

The trigger is written with an unchanged value and then with a changed value, which tells a value-sensitive reload apart from a write-sensitive one. Three sequences go to the arm register: a broken one, a correct start and a correct stop. These separate a strict two-word checker from one that reacts to the second word alone.

// File: rtl/wdog32k_pkg.sv
package wdog32k_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_REV  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ARM  = 8'h48;

  localparam logic [DATA_W-1:0] ARM_FIRST  = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] ARM_SECOND = 32'h0000_4444;
  localparam logic [DATA_W-1:0] DIS_FIRST  = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] DIS_SECOND = 32'h0000_5555;

  localparam logic [DATA_W-1:0] CNT_RST_VAL = 32'hFFFF_0000;

  // control field positions (decoded by software, so kept fixed)
  localparam int unsigned CTRL_PRE_EN_BIT = 5;
  localparam int unsigned CTRL_PTV_LSB    = 2;
  localparam int unsigned PTV_W           = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM1 = 2'd1,
    SEQ_DIS1 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wdog32k_slot.sv
module wdog32k_slot #(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             busy,
  output logic [WIDTH-1:0] data,
  output logic             commit
);
  localparam int unsigned CW = (PEND_TICKS > 1) ? $clog2(PEND_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PEND_TICKS - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_d;
  logic [WIDTH-1:0] data_d;

  assign commit = busy && tick && (cnt_q == LAST);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    data_d = data;
    if (busy) begin
      if (tick) begin
        if (cnt_q == LAST) busy_d = 1'b0;
        else               cnt_d  = cnt_q + 1'b1;
      end
    end else if (wr_req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      data  <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
      data  <= data_d;
    end
  end

  // R10: a staged write is neither lost nor overwritten before a tick
  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> busy && $stable(data));

  // R9: the pending flag drops right after the write lands
  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
endmodule

// File: rtl/wdog32k_arm_seq.sv
module wdog32k_arm_seq
  import wdog32k_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] word,
  output logic              run
);
  seq_state_e state_q, state_d;
  logic       run_d;

  always_comb begin
    state_d = state_q;
    run_d   = run;
    if (commit) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (word == ARM_FIRST)      state_d = SEQ_ARM1;
          else if (word == DIS_FIRST) state_d = SEQ_DIS1;
        end
        SEQ_ARM1: begin
          state_d = SEQ_IDLE;
          if (word == ARM_SECOND) run_d = 1'b1;
        end
        SEQ_DIS1: begin
          state_d = SEQ_IDLE;
          if (word == DIS_SECOND) run_d = 1'b0;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      run     <= 1'b0;
    end else begin
      state_q <= state_d;
      run     <= run_d;
    end
  end

  // R5: the armed state only moves when an arm-register write lands
  assert_run_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(run));

  // R3: arming requires the first word to have been accepted before
  assert_run_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(state_q) == SEQ_ARM1);
endmodule

// File: rtl/wdog32k_core.sv
module wdog32k_core
  import wdog32k_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(CNT_RST_VAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             ctrl_commit,
  input  logic [PTV_W:0]   ctrl_word,
  input  logic             load_commit,
  input  logic [CNT_W-1:0] load_word,
  input  logic             trig_commit,
  input  logic [CNT_W-1:0] trig_word,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] trig_q,
  output logic             pre_en_q,
  output logic [PTV_W-1:0] ptv_q,
  output logic             rst_req
);
  localparam int unsigned PRE_CW = (1 << PTV_W) - 1;

  logic [PRE_CW-1:0] pre_q, pre_d, pre_lim;
  logic [CNT_W-1:0]  cnt_d, load_d, trig_d;
  logic              pre_en_d, rst_req_d;
  logic [PTV_W-1:0]  ptv_d;
  logic              trig_reload, step, wrap;

  assign pre_lim     = ~({PRE_CW{1'b1}} << ptv_q);
  assign trig_reload = trig_commit && (trig_word != trig_q);
  assign step        = tick && run && (!pre_en_q || (pre_q == pre_lim));
  assign wrap        = step && (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    pre_d = pre_q;
    if (!run || trig_reload)  pre_d = '0;
    else if (tick && pre_en_q) pre_d = (pre_q == pre_lim) ? '0 : pre_q + 1'b1;

    cnt_d = cnt_q;
    if (trig_reload) cnt_d = load_q;
    else if (wrap)   cnt_d = load_q;
    else if (step)   cnt_d = cnt_q + 1'b1;

    rst_req_d = rst_req;
    if (tick) rst_req_d = wrap && !trig_reload;

    trig_d = trig_commit ? trig_word : trig_q;
    load_d = (load_commit && !run) ? load_word : load_q;

    pre_en_d = pre_en_q;
    ptv_d    = ptv_q;
    if (ctrl_commit && !run) begin
      pre_en_d = ctrl_word[PTV_W];
      ptv_d    = ctrl_word[PTV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cnt_q    <= RST_VAL;
      load_q   <= RST_VAL;
      trig_q   <= '0;
      pre_en_q <= 1'b0;
      ptv_q    <= '0;
      rst_req  <= 1'b0;
    end else begin
      pre_q    <= pre_d;
      cnt_q    <= cnt_d;
      load_q   <= load_d;
      trig_q   <= trig_d;
      pre_en_q <= pre_en_d;
      ptv_q    <= ptv_d;
      rst_req  <= rst_req_d;
    end
  end

  // R11: configuration is frozen while armed
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(load_q) && $stable(pre_en_q) && $stable(ptv_q));

  // R7: the reset request only changes on a timer tick
  assert_req_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rst_req));

  // R3: the counter never moves between ticks
  assert_cnt_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R4: a disarmed counter moves only through a trigger reload
  assert_cnt_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !trig_commit |=> $stable(cnt_q));
endmodule

// File: rtl/wdog32k_top.sv
module wdog32k_top
  import wdog32k_pkg::*;
#(
  parameter logic [7:0]  REV_CODE   = 8'h5A,
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int unsigned CTRL_W = PTV_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // posted-write staging slots
  logic              we_ctrl, we_load, we_trig, we_arm;
  logic              pend_ctrl, pend_load, pend_trig, pend_arm;
  logic              com_ctrl, com_load, com_trig, com_arm;
  logic [CTRL_W-1:0] stg_ctrl;
  logic [DATA_W-1:0] stg_load, stg_trig, stg_arm;

  assign we_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign we_load = bus_we && (bus_addr == OFS_LOAD);
  assign we_trig = bus_we && (bus_addr == OFS_TRIG);
  assign we_arm  = bus_we && (bus_addr == OFS_ARM);

  wdog32k_slot #(.WIDTH(CTRL_W), .PEND_TICKS(PEND_TICKS)) u_slot_ctrl (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .wr_req(we_ctrl),
    .wr_data(bus_wdata[CTRL_PRE_EN_BIT:CTRL_PTV_LSB]),
    .busy(pend_ctrl), .data(stg_ctrl), .commit(com_ctrl));

  wdog32k_slot #(.WIDTH(DATA_W), .PEND_TICKS(PEND_TICKS)) u_slot_load (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .wr_req(we_load),
    .wr_data(bus_wdata), .busy(pend_load), .data(stg_load), .commit(com_load));

  wdog32k_slot #(.WIDTH(DATA_W), .PEND_TICKS(PEND_TICKS)) u_slot_trig (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .wr_req(we_trig),
    .wr_data(bus_wdata), .busy(pend_trig), .data(stg_trig), .commit(com_trig));

  wdog32k_slot #(.WIDTH(DATA_W), .PEND_TICKS(PEND_TICKS)) u_slot_arm (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .wr_req(we_arm),
    .wr_data(bus_wdata), .busy(pend_arm), .data(stg_arm), .commit(com_arm));

  // arm / disarm sequencing
  logic run;

  wdog32k_arm_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .commit(com_arm), .word(stg_arm), .run(run));

  // counting core
  logic [DATA_W-1:0] cnt_q, load_q, trig_q;
  logic              pre_en_q;
  logic [PTV_W-1:0]  ptv_q;

  wdog32k_core #(.CNT_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .run(run),
    .ctrl_commit(com_ctrl), .ctrl_word(stg_ctrl),
    .load_commit(com_load), .load_word(stg_load),
    .trig_commit(com_trig), .trig_word(stg_trig),
    .cnt_q(cnt_q), .load_q(load_q), .trig_q(trig_q),
    .pre_en_q(pre_en_q), .ptv_q(ptv_q), .rst_req(rst_req));

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_REV:  bus_rdata[7:0] = REV_CODE;
      OFS_CTRL: begin
        bus_rdata[CTRL_PRE_EN_BIT] = pre_en_q;
        bus_rdata[CTRL_PTV_LSB +: PTV_W] = ptv_q;
      end
      OFS_CNT:  bus_rdata = cnt_q;
      OFS_LOAD: bus_rdata = load_q;
      OFS_TRIG: bus_rdata = trig_q;
      OFS_PEND: begin
        bus_rdata[0] = pend_ctrl;
        bus_rdata[2] = pend_load;
        bus_rdata[3] = pend_trig;
        bus_rdata[4] = pend_arm;
      end
      default:  bus_rdata = '0;
    endcase
  end

  // R10: a write arriving while its slot is busy leaves the slot busy
  assert_drop_busy_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    we_load && pend_load && !tick |=> pend_load);
endmodule

// File: tb/tb_wdog32k_top.sv
module tb_wdog32k_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_REV = 8'h00, A_CTRL = 8'h24, A_CNT = 8'h28,
    A_LOAD = 8'h2C, A_TRIG = 8'h30, A_PEND = 8'h34, A_ARM = 8'h48;

  wdog32k_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .rst_req(rst_req));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic posted(input logic [7:0] a, input logic [31:0] d);
    bus_wr(a, d);
    ticks(2);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CNT, v);  chk("R1 counter", v, 32'hFFFF0000);
    rd(A_LOAD, v); chk("R1 load", v, 32'hFFFF0000);
    rd(A_TRIG, v); chk("R1 trigger", v, 32'h0);
    rd(A_CTRL, v); chk("R1 control", v, 32'h0);
    rd(A_PEND, v); chk("R1 pending", v, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
  endtask

  task automatic t_revision;
    logic [31:0] v;
    rd(A_REV, v); chk("R2 revision", v, 32'h5A);
    posted(A_REV, 32'hFFFF_FFFF);
    rd(A_REV, v); chk("R2 revision after write", v, 32'h5A);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    bus_wr(A_LOAD, 32'hFFFF_FFF0);
    rd(A_PEND, v); chk("R9 load pending bit2", v, 32'h4);
    bus_wr(A_LOAD, 32'h1111_1111);
    ticks(1);
    rd(A_PEND, v); chk("R9 still pending after one tick", v, 32'h4);
    ticks(1);
    rd(A_PEND, v); chk("R9 cleared after two ticks", v, 32'h0);
    rd(A_LOAD, v); chk("R10 second write dropped", v, 32'hFFFF_FFF0);
    bus_wr(A_CTRL, 32'h0);
    rd(A_PEND, v); chk("R9 control pending bit0", v, 32'h1);
    ticks(2);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    bus_wr(A_TRIG, 32'h0);
    rd(A_PEND, v); chk("R9 trigger pending bit3", v, 32'h8);
    ticks(2);
    rd(A_CNT, v); chk("R6 same value no reload", v, 32'hFFFF0000);
    posted(A_TRIG, 32'h1);
    rd(A_CNT, v); chk("R6 changed value reloads", v, 32'hFFFF_FFF0);
    rd(A_TRIG, v); chk("R6 trigger readback", v, 32'h1);
  endtask

  task automatic t_bad_seq;
    logic [31:0] v;
    bus_wr(A_ARM, 32'hBBBB);
    rd(A_PEND, v); chk("R9 arm pending bit4", v, 32'h10);
    ticks(2);
    posted(A_ARM, 32'h1234);
    posted(A_ARM, 32'h4444);
    ticks(3);
    rd(A_CNT, v); chk("R5 broken sequence stays disarmed", v, 32'hFFFF_FFF0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    posted(A_LOAD, 32'hFFFF_FFF8);
    posted(A_TRIG, 32'h0);
    posted(A_ARM, 32'hBBBB);
    posted(A_ARM, 32'h4444);
    rd(A_CNT, v); chk("R3 armed, not yet counted", v, 32'hFFFF_FFF8);
    ticks(1);
    rd(A_CNT, v); chk("R3 one step per tick", v, 32'hFFFF_FFF9);
    ticks(6);
    rd(A_CNT, v); chk("R7 at all ones", v, 32'hFFFF_FFFF);
    chk("R7 no request before wrap", {31'h0, rst_req}, 32'h0);
    ticks(1);
    rd(A_CNT, v); chk("R7 reload on wrap", v, 32'hFFFF_FFF8);
    chk("R7 request raised", {31'h0, rst_req}, 32'h1);
    ticks(1);
    chk("R7 request dropped", {31'h0, rst_req}, 32'h0);
    rd(A_CNT, v); chk("R7 counting resumes", v, 32'hFFFF_FFF9);
  endtask

  task automatic t_frozen_and_stop;
    logic [31:0] v, held;
    posted(A_LOAD, 32'h0);
    rd(A_LOAD, v); chk("R11 load ignored while armed", v, 32'hFFFF_FFF8);
    posted(A_CTRL, 32'h28);
    rd(A_CTRL, v); chk("R11 control ignored while armed", v, 32'h0);
    posted(A_ARM, 32'hAAAA);
    posted(A_ARM, 32'h5555);
    rd(A_CNT, held);
    ticks(3);
    rd(A_CNT, v); chk("R4 disarmed counter holds", v, held);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    posted(A_CTRL, 32'h28);
    rd(A_CTRL, v); chk("R8 control readback", v, 32'h28);
    posted(A_LOAD, 32'hFFFF_FF00);
    posted(A_TRIG, 32'h1);
    posted(A_ARM, 32'hBBBB);
    posted(A_ARM, 32'h4444);
    ticks(3);
    rd(A_CNT, v); chk("R8 no step before 4 ticks", v, 32'hFFFF_FF00);
    ticks(1);
    rd(A_CNT, v); chk("R8 step on 4th tick", v, 32'hFFFF_FF01);
    ticks(4);
    rd(A_CNT, v); chk("R8 next step after 4 more", v, 32'hFFFF_FF02);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_revision();
    t_pending();
    t_trigger();
    t_bad_seq();
    t_overflow();
    t_frozen_and_stop();
    t_prescale();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule